// File: doc/BRIEF.md
# Quad DAC Serial Command Controller

This block is the digital command core of a four-channel, 12-bit digital-to-analog converter. A host sends 24-bit command words over a three-wire serial link: a serial clock, an active-low frame select and a data line. The block brings those pins into the system clock domain, oversamples them and shifts in one bit on each falling serial-clock edge while the frame select is low. When the frame select rises after exactly 24 bits, the command and address fields are decoded and the command is applied.

The block holds a 12-bit DAC code and a 2-bit power-down mode for each channel, a 4-bit load-mask register and a one-bit reference-enable register, and presents all of them as registered outputs. A power-down/power-up command sets a mode on any subset of channels and leaves their stored codes alone. A software reset command has two depths. The shallow one clears the codes. The deep one also clears the modes, the load mask and the reference enable. A one-cycle `frame_done` pulse marks the clock cycle in which a decoded command takes effect.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After `rst_n` is released, every channel code, every power-down mode, the load mask and the reference enable read zero, and `frame_done` is low.
- R2: A frame begins when `sync_n` falls, and data is taken MSB first on falling `sclk` edges. The frame executes when `sync_n` rises only if exactly 24 bits were taken. A frame of any other length changes nothing and gives no `frame_done` pulse.
- R3: Command 3'b011 (word bits 21:19) writes word bits 15:4 into the code of the channel chosen by bits 18:16 (0=A, 1=B, 2=C, 3=D, 7=all four). Addresses 4 to 6 select no channel.
- R4: Command 3'b100 copies word bits 5:4 (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 three-state) into the mode of every channel whose bit is set in word bits 3:0 (bit 0 = A ... bit 3 = D). Channels with a clear mask bit keep their mode.
- R5: A power-down/power-up command leaves every channel code unchanged.
- R6: Command 3'b101 with word bit 0 = 0 clears every channel code and leaves the modes, the load mask and the reference enable unchanged. Word bits 15:1 have no effect.
- R7: Command 3'b101 with word bit 0 = 1 clears every channel code, every mode, the load mask and the reference enable.
- R8: Command 3'b110 loads word bits 3:0 into the load mask. Command 3'b111 loads word bit 0 into the reference enable.
- R9: Commands 3'b000, 3'b001 and 3'b010 are accepted (they produce `frame_done`) and change no output register. Word bits 23:22 are ignored by every command.
- R10: `frame_done` is high for exactly one cycle per executed frame. It is high in the same cycle that the new register values first appear, which is the third rising `clk` edge after `sync_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| dac_code | output | 48 | Channel codes, channel n at bits 12n+11:12n |
| pd_mode | output | 8 | Channel power-down modes, channel n at bits 2n+1:2n |
| ldac_mask | output | 4 | Load-mask register |
| ref_en | output | 1 | Reference-enable register |
| frame_done | output | 1 | One-cycle pulse when a command takes effect |

## Verification
The case that is hardest to reach from the ports is telling the two reset depths apart. The deep reset only differs from the shallow one when the modes, the load mask and the reference enable already hold nonzero values, so the stimulus first loads all three with distinct patterns and writes nonzero codes. It then issues the shallow reset with every ignored data bit set, refills the state, and issues the deep reset. Malformed frames of 23 and 25 bits are sent, carrying write commands that would otherwise be visible, to show they are dropped. A behavioural model is compared with every output on each clock, so a pulse one cycle early or late is caught.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int N_CH     = 4;
  localparam int CODE_W   = 12;
  localparam int MODE_W   = 2;
  localparam int FRAME_W  = 24;
  localparam int KEEP_W   = FRAME_W - 2;
  localparam int CMD_W    = 3;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int CMD_LSB  = 19;
  localparam int ADDR_LSB = 16;
  localparam int CODE_LSB = 4;
  localparam int MODE_LSB = 4;

  localparam logic [CMD_W-1:0] CMD_WRUPD = 3'b011;
  localparam logic [CMD_W-1:0] CMD_POWER = 3'b100;
  localparam logic [CMD_W-1:0] CMD_RESET = 3'b101;
  localparam logic [CMD_W-1:0] CMD_LMASK = 3'b110;
  localparam logic [CMD_W-1:0] CMD_REFEN = 3'b111;

  typedef struct packed {
    logic              done;
    logic              wrCode;
    logic              pdSet;
    logic              softRst;
    logic              fullRst;
    logic              ldacWr;
    logic              refWr;
    logic [N_CH-1:0]   chSel;
    logic [CODE_W-1:0] code;
    logic [MODE_W-1:0] mode;
    logic [N_CH-1:0]   ldacVal;
    logic              refVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/qdac_sync2.sv
module qdac_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sync_n,
  input  logic        din,
  output ctrlStrobe_t strobe
);
  logic sclkS, syncS, dinS;
  logic sclkPrev, syncPrev;
  logic sclkFall, syncFall, syncRise;
  logic framing;
  logic [CNT_W-1:0] bitCnt;
  logic [KEEP_W-1:0] shiftReg;
  logic [CMD_W-1:0] cmd;
  logic [2:0] addr;
  logic frameOk;
  logic [N_CH-1:0] addrSel;

  qdac_sync2 #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, sync_n, din}),
    .q({sclkS, syncS, dinS})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      syncPrev <= syncS;
    end
  end

  assign sclkFall = sclkPrev & ~sclkS;
  assign syncFall = syncPrev & ~syncS;
  assign syncRise = ~syncPrev & syncS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      framing  <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (syncFall) begin
      framing  <= 1'b1;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (syncRise) begin
      framing  <= 1'b0;
    end else if (framing && sclkFall) begin
      shiftReg <= {shiftReg[KEEP_W-2:0], dinS};
      if (bitCnt != CNT_W'(FRAME_W + 1)) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign cmd     = shiftReg[CMD_LSB +: CMD_W];
  assign addr    = shiftReg[ADDR_LSB +: 3];
  assign frameOk = syncRise & framing & (bitCnt == CNT_W'(FRAME_W));

  for (genvar i = 0; i < N_CH; i++) begin : g_addr
    assign addrSel[i] = (addr == 3'(i)) || (addr == 3'b111);
  end

  always_comb begin
    strobe         = '0;
    strobe.done    = frameOk;
    strobe.wrCode  = frameOk && (cmd == CMD_WRUPD);
    strobe.pdSet   = frameOk && (cmd == CMD_POWER);
    strobe.softRst = frameOk && (cmd == CMD_RESET);
    strobe.fullRst = frameOk && (cmd == CMD_RESET) && shiftReg[0];
    strobe.ldacWr  = frameOk && (cmd == CMD_LMASK);
    strobe.refWr   = frameOk && (cmd == CMD_REFEN);
    strobe.chSel   = (cmd == CMD_POWER) ? shiftReg[N_CH-1:0] : addrSel;
    strobe.code    = shiftReg[CODE_LSB +: CODE_W];
    strobe.mode    = shiftReg[MODE_LSB +: MODE_W];
    strobe.ldacVal = shiftReg[N_CH-1:0];
    strobe.refVal  = shiftReg[0];
  end

  // R2: each falling serial edge inside a frame advances the bit count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (framing && sclkFall && !syncFall && !syncRise && bitCnt < CNT_W'(FRAME_W + 1))
      |=> (bitCnt == $past(bitCnt) + 1'b1));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobe_t              strobe,
  output logic [N_CH*CODE_W-1:0]   dacCode,
  output logic [N_CH*MODE_W-1:0]   pdMode,
  output logic [N_CH-1:0]          ldacMask,
  output logic                     refEn,
  output logic                     frameDone
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dacCode[ch*CODE_W +: CODE_W] <= '0;
      end else if (strobe.softRst) begin
        dacCode[ch*CODE_W +: CODE_W] <= '0;
      end else if (strobe.wrCode && strobe.chSel[ch]) begin
        dacCode[ch*CODE_W +: CODE_W] <= strobe.code;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pdMode[ch*MODE_W +: MODE_W] <= '0;
      end else if (strobe.fullRst) begin
        pdMode[ch*MODE_W +: MODE_W] <= '0;
      end else if (strobe.pdSet && strobe.chSel[ch]) begin
        pdMode[ch*MODE_W +: MODE_W] <= strobe.mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldacMask  <= '0;
      refEn     <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strobe.done;
      if (strobe.fullRst) begin
        ldacMask <= '0;
        refEn    <= 1'b0;
      end else begin
        if (strobe.ldacWr) ldacMask <= strobe.ldacVal;
        if (strobe.refWr)  refEn    <= strobe.refVal;
      end
    end
  end

  // R10: completion never lasts two cycles
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  // R5: a power command leaves every stored code alone
  p_pd_keeps_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pdSet |=> $stable(dacCode));

  // R6: shallow reset leaves modes, mask and reference alone
  p_soft_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.softRst && !strobe.fullRst) |=> ($stable(pdMode) && $stable(ldacMask) && $stable(refEn)));

  // R7: deep reset clears everything
  p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fullRst |=> (dacCode == '0 && pdMode == '0 && ldacMask == '0 && !refEn));

  // R9: without a decoded frame no register moves
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.done |=> ($stable(dacCode) && $stable(pdMode) && $stable(ldacMask) && $stable(refEn)));
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   sync_n,
  input  logic                   din,
  output logic [N_CH*CODE_W-1:0] dac_code,
  output logic [N_CH*MODE_W-1:0] pd_mode,
  output logic [N_CH-1:0]        ldac_mask,
  output logic                   ref_en,
  output logic                   frame_done
);
  ctrlStrobe_t strobe;

  qdac_serial_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclk(sclk), .sync_n(sync_n), .din(din),
    .strobe(strobe)
  );

  qdac_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .dacCode(dac_code), .pdMode(pd_mode),
    .ldacMask(ldac_mask), .refEn(ref_en), .frameDone(frame_done)
  );
endmodule

// File: tb/quad_dac_ctrl_tb_top.sv
module quad_dac_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sync_n = 1'b1;
  logic din = 1'b0;
  logic [47:0] dac_code;
  logic [7:0]  pd_mode;
  logic [3:0]  ldac_mask;
  logic        ref_en;
  logic        frame_done;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit cmpOn = 1'b0;
  bit expDone = 1'b0;
  bit finished = 1'b0;

  logic [11:0] mCode [4];
  logic [1:0]  mMode [4];
  logic [3:0]  mLdac;
  logic        mRef;

  always #4 clk = ~clk;

  quad_dac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .dac_code(dac_code), .pd_mode(pd_mode), .ldac_mask(ldac_mask),
    .ref_en(ref_en), .frame_done(frame_done)
  );

  function automatic logic [47:0] expCodes();
    logic [47:0] v;
    for (int c = 0; c < 4; c++) v[c*12 +: 12] = mCode[c];
    return v;
  endfunction

  function automatic logic [7:0] expModes();
    logic [7:0] v;
    for (int c = 0; c < 4; c++) v[c*2 +: 2] = mMode[c];
    return v;
  endfunction

  function automatic logic [23:0] mk(logic [2:0] cmd, logic [2:0] addr, logic [15:0] data);
    return {2'b11, cmd, addr, data};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      checks++;
      if (dac_code !== expCodes() || pd_mode !== expModes() || ldac_mask !== mLdac ||
          ref_en !== mRef || frame_done !== expDone) begin
        failures++;
        $display("FAIL %s per-cycle act=%h/%h/%h/%b/%b exp=%h/%h/%h/%b/%b", curReq,
                 dac_code, pd_mode, ldac_mask, ref_en, frame_done,
                 expCodes(), expModes(), mLdac, mRef, expDone);
      end
    end
  end

  task automatic applyModel(logic [23:0] w);
    case (w[21:19])
      3'b011: for (int c = 0; c < 4; c++) if (w[18:16] == 3'(c) || w[18:16] == 3'b111) mCode[c] = w[15:4];
      3'b100: for (int c = 0; c < 4; c++) if (w[c]) mMode[c] = w[5:4];
      3'b101: begin
        for (int c = 0; c < 4; c++) mCode[c] = '0;
        if (w[0]) begin
          for (int c = 0; c < 4; c++) mMode[c] = '0;
          mLdac = '0;
          mRef = 1'b0;
        end
      end
      3'b110: mLdac = w[3:0];
      3'b111: mRef = w[0];
      default: ;
    endcase
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(logic [23:0] w, int nbits, bit execs);
    @(negedge clk);
    sync_n = 1'b0;
    hold(4);
    for (int k = 0; k < nbits; k++) begin
      din = (k < 24) ? w[23-k] : 1'b1;
      sclk = 1'b1;
      hold(4);
      sclk = 1'b0;
      hold(4);
    end
    sclk = 1'b1;
    hold(4);
    sync_n = 1'b1;
    repeat (3) @(posedge clk);
    if (execs) begin
      applyModel(w);
      expDone = 1'b1;
    end
    @(posedge clk);
    expDone = 1'b0;
    hold(3);
  endtask

  task automatic send(logic [23:0] w);
    sendBits(w, 24, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mCode[c] = '0; mMode[c] = '0; end
    mLdac = '0;
    mRef = 1'b0;
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // R1: reset state
    chk("R1", "codes", 64'(dac_code), 64'h0);
    chk("R1", "modes", 64'(pd_mode), 64'h0);
    chk("R1", "mask/ref/done", 64'({ldac_mask, ref_en, frame_done}), 64'h0);
    cmpOn = 1'b1;

    // R3: single-channel and broadcast writes
    curReq = "R3";
    send(mk(3'b011, 3'd0, {12'hABC, 4'hF}));
    chk("R3", "chA", 64'(dac_code[11:0]), 64'hABC);
    send(mk(3'b011, 3'd2, {12'h3C5, 4'h0}));
    send(mk(3'b011, 3'd3, {12'hFFF, 4'h0}));
    chk("R3", "chC/D", 64'(dac_code[47:24]), 64'hFFF3C5);
    send(mk(3'b011, 3'd5, {12'h777, 4'h0}));
    chk("R3", "bad addr", 64'(dac_code), 64'hFFF3C5000ABC);
    send(mk(3'b011, 3'd7, {12'h555, 4'h0}));
    send(mk(3'b011, 3'd1, {12'h123, 4'h0}));
    chk("R3", "all then B", 64'(dac_code), 64'h555555123555);

    // R4 and R5: power-down on subsets
    curReq = "R4";
    send(mk(3'b100, 3'd0, 16'hFF15));
    chk("R4", "mode 01 on A,C", 64'(pd_mode), 64'h11);
    chk("R5", "codes kept", 64'(dac_code), 64'h555555123555);
    send(mk(3'b100, 3'd2, 16'h0038));
    chk("R4", "mode 11 on D", 64'(pd_mode), 64'hD1);
    send(mk(3'b100, 3'd0, 16'h0001));
    chk("R4", "power up A", 64'(pd_mode), 64'hD0);
    send(mk(3'b100, 3'd0, 16'h0022));
    chk("R4", "mode 10 on B", 64'(pd_mode), 64'hD8);
    chk("R5", "codes kept after modes", 64'(dac_code), 64'h555555123555);

    // R8: load mask and reference enable
    curReq = "R8";
    send(mk(3'b110, 3'd0, 16'hFFFA));
    send(mk(3'b111, 3'd0, 16'h0001));
    chk("R8", "mask/ref", 64'({ldac_mask, ref_en}), 64'h15);

    // R9: unhandled commands
    curReq = "R9";
    send(mk(3'b000, 3'd7, 16'hFFFF));
    send(mk(3'b001, 3'd7, 16'hFFFF));
    send(mk(3'b010, 3'd7, 16'hFFFF));
    chk("R9", "codes untouched", 64'(dac_code), 64'h555555123555);
    chk("R9", "modes untouched", 64'(pd_mode), 64'hD8);

    // R2: wrong frame lengths are dropped
    curReq = "R2";
    sendBits(mk(3'b011, 3'd7, 16'h0000), 23, 1'b0);
    chk("R2", "23-bit frame", 64'(dac_code), 64'h555555123555);
    sendBits(mk(3'b011, 3'd7, 16'h0000), 25, 1'b0);
    chk("R2", "25-bit frame", 64'(dac_code), 64'h555555123555);

    // R6: shallow reset with ignored bits set
    curReq = "R6";
    send(mk(3'b101, 3'd7, 16'hFFFE));
    chk("R6", "codes cleared", 64'(dac_code), 64'h0);
    chk("R6", "state kept", 64'({pd_mode, ldac_mask, ref_en}), 64'({8'hD8, 4'hA, 1'b1}));

    // R7: deep reset
    curReq = "R7";
    send(mk(3'b011, 3'd7, {12'h9A9, 4'h0}));
    send(mk(3'b101, 3'd0, 16'h0001));
    chk("R7", "all cleared", 64'({dac_code, pd_mode, ldac_mask, ref_en}), 64'h0);

    // R10: done pulse returns low and stays low
    curReq = "R10";
    hold(5);
    chk("R10", "done idle", 64'(frame_done), 64'h0);

    finished = 1'b1;
    cmpOn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule